// File: doc/BRIEF.md
# Sequential Booth Multiplier for Signed Operands

This block multiplies two signed two's-complement operands of `WIDTH` bits each and returns a signed product of `2*WIDTH` bits. It uses radix-2 Booth recoding and finishes one multiplier bit per clock. On each step it looks at the lowest bit of the multiplier together with the bit examined in the step before. Where a run of ones in the multiplier begins, it subtracts the multiplicand from the upper half of an accumulator. Where a run of ones ends, it adds the multiplicand. For the patterns 00 and 11 it leaves the accumulator unchanged. In every case the accumulator pair is then shifted right with the sign preserved.

The surrounding logic pulses `start_i` with both operands present. The block samples the operands in that cycle, raises `busy_o`, and takes exactly `WIDTH` further clock cycles. It then presents the product and pulses `done_o` for one cycle. The product stays on `product_o` until the next accepted start. A start request that arrives while an operation is running is dropped.

Top module: `booth_seq_mult`

## Requirements
- R1: While synchronous active-low reset is applied and directly after it, `busy_o` is 0, `done_o` is 0 and `product_o` is all zeros.
- R2: `start_i` high while `busy_o` is 0 captures both operand inputs at that clock edge and sets `busy_o` from the next cycle. Changes to the operand inputs after that edge do not affect the result.
- R3: `done_o` is high for exactly one cycle. It rises `WIDTH` clock edges after the edge that accepted the start, and `busy_o` is 0 in that same cycle.
- R4: When `done_o` is high, `product_o` is the exact signed product of the captured multiplicand and multiplier, as a `2*WIDTH`-bit two's-complement value.
- R5: The recoding of the pair (current lowest multiplier bit, previous bit) is fixed: 10 subtracts the multiplicand, 01 adds it, and 00 or 11 only shift. This is checked with multipliers made of isolated ones, long runs of ones and alternating bits.
- R6: Multiplying the most negative value by itself yields the correct positive product 2^(2*WIDTH-2). Multiplying the most negative value by -1, by 1 and by the most positive value is also correct.
- R7: A start request while `busy_o` is 1 is ignored. The running operation completes with its own operands and its own latency.
- R8: Between the cycle `done_o` is high and the next accepted start, `product_o` does not change, whatever the operand inputs do.
- R9: Each step shifts the accumulator pair right arithmetically. Negative products therefore come out correctly sign-extended across the full `2*WIDTH` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication; accepted only when idle |
| multiplicand_i | input | WIDTH | Signed multiplicand, sampled on an accepted start |
| multiplier_i | input | WIDTH | Signed multiplier, sampled on an accepted start |
| busy_o | output | 1 | High while the iterations are running |
| done_o | output | 1 | One-cycle pulse when the product becomes valid |
| product_o | output | 2*WIDTH | Signed product, held until the next accepted start |

## Verification
The bench builds two copies of the block. The first uses `WIDTH` = 8. It runs directed operand pairs and a few hundred pseudo-random pairs, and this copy also carries the start-while-busy, operand-change and hold scenarios. The second uses `WIDTH` = 4, which is small enough to run every one of the 256 operand pairs. That exhaustive run reaches every recoding sequence, including both most-negative corner cases at that width.

// File: rtl/booth_pkg.sv
// Package: shared types for the sequential Booth multiplier.
// Assumes nothing beyond being compiled before the modules that import it.
package booth_pkg;

    // Action chosen by recoding one multiplier bit pair
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

    // Control states of the iteration sequencer
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } booth_state_e;

endpackage

// File: rtl/booth_recode.sv
// Module: booth_recode
// Maps the pair (current lowest multiplier bit, previously examined bit)
// to a radix-2 Booth action. Purely combinational.
// Assumes the previous bit is zero for the first step of an operation.
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur_bit_i,
    input  logic      prev_bit_i,
    output booth_op_e op_o
);

    // Decode the bit pair into subtract / add / hold
    always_comb begin
        unique case ({cur_bit_i, prev_bit_i})
            2'b10:   op_o = OP_SUB;
            2'b01:   op_o = OP_ADD;
            default: op_o = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/booth_addsub.sv
// Module: booth_addsub
// One shared adder. It adds the operand, subtracts it (as acc + ~operand + 1),
// or passes the accumulator through unchanged.
// Assumes both inputs are already sign-extended to ACC_W bits.
module booth_addsub
    import booth_pkg::*;
#(
    parameter int ACC_W = 9
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] operand_i,
    input  booth_op_e        op_i,
    output logic [ACC_W-1:0] acc_o
);

    logic             sub;
    logic [ACC_W-1:0] opnd;
    logic [ACC_W-1:0] sum;

    // Conditionally invert the operand and inject the carry for subtraction
    always_comb begin
        sub   = (op_i == OP_SUB);
        opnd  = sub ? ~operand_i : operand_i;
        sum   = acc_i + opnd + ACC_W'(sub);
        acc_o = (op_i == OP_HOLD) ? acc_i : sum;
    end

endmodule

// File: rtl/booth_shift.sv
// Module: booth_shift
// Shifts the accumulator:low pair one place right with the sign kept.
// Rotates the multiplier one place right and emits its old lowest bit
// as the new "previous" bit. Purely combinational.
// Assumes the accumulator is WIDTH+1 bits wide (one guard bit).
module booth_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH:0]   acc_i,
    input  logic [WIDTH-1:0] low_i,
    input  logic [WIDTH-1:0] mult_i,
    output logic [WIDTH:0]   acc_o,
    output logic [WIDTH-1:0] low_o,
    output logic [WIDTH-1:0] mult_o,
    output logic             prev_o
);

    // Arithmetic shift of the accumulator pair and rotation of the multiplier
    always_comb begin
        acc_o  = {acc_i[WIDTH], acc_i[WIDTH:1]};
        low_o  = {acc_i[0], low_i[WIDTH-1:1]};
        mult_o = {mult_i[0], mult_i[WIDTH-1:1]};
        prev_o = mult_i[0];
    end

endmodule

// File: rtl/booth_ctrl.sv
// Module: booth_ctrl
// Sequencer. It accepts a start when idle, runs WIDTH steps, then pulses
// done for one cycle. Starts that arrive while running are ignored.
// Assumes synchronous active-low reset.
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    booth_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;

    // Decode control strobes from the state and the step counter
    always_comb begin
        load_o = (state_q == ST_IDLE) && start_i;
        step_o = (state_q == ST_RUN);
        last_o = step_o && (cnt_q == LAST_STEP);
        busy_o = (state_q == ST_RUN);
    end

    // State, step counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= last_o;
            if (load_o) begin
                state_q <= ST_RUN;
                cnt_q   <= '0;
            end else if (last_o) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
            end else if (step_o) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/booth_seq_mult.sv
// Module: booth_seq_mult (top)
// Radix-2 Booth multiplier for signed operands, one multiplier bit per clock.
// The accumulator has one guard bit, so subtracting the most negative
// multiplicand cannot overflow.
// Assumes operands are stable only in the cycle start_i is accepted.
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WIDTH-1:0]   multiplicand_i,
    input  logic [WIDTH-1:0]   multiplier_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [2*WIDTH-1:0] product_o
);

    localparam int ACC_W  = WIDTH + 1;
    localparam int PROD_W = 2 * WIDTH;

    logic [ACC_W-1:0]  mcand_q;
    logic [ACC_W-1:0]  acc_q;
    logic [WIDTH-1:0]  low_q;
    logic [WIDTH-1:0]  mult_q;
    logic              prev_q;
    logic [PROD_W-1:0] prod_q;

    logic              load, step, last;
    booth_op_e         op;
    logic [ACC_W-1:0]  acc_sum;
    logic [ACC_W-1:0]  acc_sh;
    logic [WIDTH-1:0]  low_sh;
    logic [WIDTH-1:0]  mult_rot;
    logic              prev_nxt;

    booth_ctrl #(.WIDTH(WIDTH)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    booth_recode i_recode (
        .cur_bit_i  (mult_q[0]),
        .prev_bit_i (prev_q),
        .op_o       (op)
    );

    booth_addsub #(.ACC_W(ACC_W)) i_addsub (
        .acc_i     (acc_q),
        .operand_i (mcand_q),
        .op_i      (op),
        .acc_o     (acc_sum)
    );

    booth_shift #(.WIDTH(WIDTH)) i_shift (
        .acc_i  (acc_sum),
        .low_i  (low_q),
        .mult_i (mult_q),
        .acc_o  (acc_sh),
        .low_o  (low_sh),
        .mult_o (mult_rot),
        .prev_o (prev_nxt)
    );

    // Datapath registers: load on accepted start, advance once per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
            low_q   <= '0;
            mult_q  <= '0;
            prev_q  <= 1'b0;
        end else if (load) begin
            mcand_q <= {multiplicand_i[WIDTH-1], multiplicand_i};
            acc_q   <= '0;
            low_q   <= '0;
            mult_q  <= multiplier_i;
            prev_q  <= 1'b0;
        end else if (step) begin
            acc_q  <= acc_sh;
            low_q  <= low_sh;
            mult_q <= mult_rot;
            prev_q <= prev_nxt;
        end
    end

    // Result register: captured on the final step, held until the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (last) begin
            prod_q <= {acc_sh[WIDTH-1:0], low_sh};
        end
    end

    assign product_o = prod_q;

endmodule

// File: rtl/booth_seq_mult_chk.sv
// Module: booth_seq_mult_chk
// Assertion checker bound to every instance of booth_seq_mult.
// Assumes synchronous active-low reset on rst_n.
module booth_seq_mult_chk #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [WIDTH-1:0]   multiplicand_i,
    input logic [WIDTH-1:0]   multiplier_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [2*WIDTH-1:0] product_o
);

    localparam int CW = $clog2(WIDTH + 1) + 1;

    logic signed [WIDTH-1:0]   a_q, b_q;
    logic signed [2*WIDTH-1:0] expect_prod;
    logic [CW-1:0]             busy_cnt;

    // Capture operands on accepted start; count busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            busy_cnt <= '0;
        end else if (start_i && !busy_o) begin
            a_q      <= multiplicand_i;
            b_q      <= multiplier_i;
            busy_cnt <= '0;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    assign expect_prod = (2*WIDTH)'(a_q) * (2*WIDTH)'(b_q);

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy_o && !done_o && product_o == '0));

    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r3_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt == CW'(WIDTH)));

    a_r4_product_matches: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (product_o == expect_prod));

    a_r8_product_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(product_o));

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.WIDTH(WIDTH)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .multiplicand_i (multiplicand_i),
    .multiplier_i   (multiplier_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .product_o      (product_o)
);

// File: tb/test_booth_seq_mult.sv
module test_booth_seq_mult;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // 8-bit instance
    logic        s8 = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic        busy8, done8;
    logic [15:0] p8;

    // 4-bit instance for exhaustive coverage
    logic        s4 = 1'b0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic        busy4, done4;
    logic [7:0]  p4;

    booth_seq_mult #(.WIDTH(8)) i_booth_seq_mult (
        .clk(clk), .rst_n(rst_n), .start_i(s8), .multiplicand_i(a8),
        .multiplier_i(b8), .busy_o(busy8), .done_o(done8), .product_o(p8));

    booth_seq_mult #(.WIDTH(4)) i_booth_seq_mult_w4 (
        .clk(clk), .rst_n(rst_n), .start_i(s4), .multiplicand_i(a4),
        .multiplier_i(b4), .busy_o(busy4), .done_o(done4), .product_o(p4));

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
                finish_run();
            end
        end
    end

    // One 8-bit multiplication; scramble changes the operand inputs after acceptance (R2)
    task automatic do_mul8(input logic signed [7:0] a, input logic signed [7:0] b,
                           input string req, input bit scramble);
        int cyc;
        longint exp;
        exp = longint'(a) * longint'(b);
        @(negedge clk);
        a8 = a; b8 = b; s8 = 1'b1;
        @(negedge clk);
        s8 = 1'b0;
        if (scramble) begin a8 = ~a; b8 = b ^ 8'h5A; end
        check(busy8 && !done8, "R2", "busy after start", longint'(busy8), 1);
        cyc = 0;
        while (!done8 && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == 8, "R3", "latency", cyc, 8);
        check(!busy8, "R3", "busy low with done", longint'(busy8), 0);
        check(longint'($signed(p8)) == exp, req, "product", longint'($signed(p8)), exp);
        @(negedge clk);
        check(!done8, "R3", "done single pulse", longint'(done8), 0);
    endtask

    task automatic do_mul4(input int a, input int b);
        int cyc;
        longint exp;
        exp = longint'(a) * longint'(b);
        @(negedge clk);
        a4 = 4'(a); b4 = 4'(b); s4 = 1'b1;
        @(negedge clk);
        s4 = 1'b0;
        cyc = 0;
        while (!done4 && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc == 4, "R3", "w4 latency", cyc, 4);
        check(longint'($signed(p4)) == exp, "R4", "w4 product", longint'($signed(p4)), exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy8 && !done8, "R1", "busy/done in reset", longint'({busy8, done8}), 0);
        check(p8 == '0, "R1", "product in reset", longint'(p8), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy8 && !done8 && p8 == '0, "R1", "idle after reset", longint'(p8), 0);
        check(!busy4 && !done4 && p4 == '0, "R1", "w4 idle after reset", longint'(p4), 0);
    endtask

    task automatic t_recoding();
        do_mul8(8'sd13, 8'sd0, "R5", 1'b0);
        do_mul8(8'sd13, 8'sd1, "R5", 1'b0);
        do_mul8(8'sd37, 8'sh55, "R5", 1'b0);   // alternating bits
        do_mul8(-8'sd37, 8'shAA - 8'sd0, "R5", 1'b0);
        do_mul8(8'sd19, 8'sh3C, "R5", 1'b0);   // single run of ones
        do_mul8(-8'sd7, -8'sd1, "R5", 1'b0);   // all ones
        do_mul8(8'sd100, 8'sh24, "R5", 1'b0);  // isolated ones
    endtask

    task automatic t_sign();
        do_mul8(-8'sd5, 8'sd3, "R9", 1'b0);
        do_mul8(8'sd127, -8'sd127, "R9", 1'b0);
        do_mul8(-8'sd1, 8'sd1, "R9", 1'b0);
    endtask

    task automatic t_extremes();
        do_mul8(-8'sd128, -8'sd128, "R6", 1'b0);
        do_mul8(-8'sd128, -8'sd1, "R6", 1'b0);
        do_mul8(-8'sd128, 8'sd127, "R6", 1'b0);
        do_mul8(8'sd127, -8'sd128, "R6", 1'b0);
        do_mul8(-8'sd128, 8'sd1, "R6", 1'b0);
    endtask

    task automatic t_capture();
        do_mul8(8'sd45, -8'sd22, "R2", 1'b1);
        do_mul8(-8'sd128, 8'sd99, "R2", 1'b1);
    endtask

    task automatic t_start_busy();
        int cyc;
        @(negedge clk);
        a8 = 8'd21; b8 = 8'd6; s8 = 1'b1;
        @(negedge clk);
        a8 = 8'd90; b8 = 8'd77;
        cyc = 0;
        while (!done8 && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (cyc == 3) s8 = 1'b0;
        end
        s8 = 1'b0;
        check(cyc == 8, "R7", "latency with start while busy", cyc, 8);
        check(longint'($signed(p8)) == 126, "R7", "product unaffected", longint'($signed(p8)), 126);
    endtask

    task automatic t_hold();
        logic [15:0] held;
        do_mul8(-8'sd9, 8'sd11, "R4", 1'b0);
        held = p8;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            a8 = 8'(i * 37); b8 = 8'(i * 53);
        end
        check(p8 == held, "R8", "product held", longint'(p8), longint'(held));
        check(!busy8, "R8", "no run without start", longint'(busy8), 0);
    endtask

    task automatic t_random();
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_mul8(lfsr[7:0], lfsr[15:8], "R4", 1'b0);
        end
    endtask

    task automatic t_exhaustive4();
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                do_mul4(a, b);
            end
        end
    endtask

    initial begin
        t_reset();
        t_recoding();
        t_sign();
        t_extremes();
        t_capture();
        t_start_busy();
        t_hold();
        t_random();
        t_exhaustive4();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule